// File: doc/BRIEF.md
# Reset Cause Flag Register

This block records why the processor most recently came out of reset or woke from sleep. Every possible cause reaches it as a one-cycle strobe. From each strobe it updates a primary eight-bit cause register, a secondary three-bit fault register, two processor status bits (time-out and power-down) and a resume select that picks where execution continues. Each cause has its own pattern of bits that it sets, clears or leaves alone. For that reason the registers are a history of cause indications, and software reads it and then re-arms it.

Software re-arms the flags through a simple write port. The write lands only in a cycle with no event strobe, so a reset cause can never be lost to a write that arrives at the same time. Several strobes in one cycle are resolved by a fixed priority and a merge rule. The block does not generate the resets themselves.

Top module: `rcf_top`

## Requirements
- R1: After synchronous reset `rst`, main flags are 0x3C, aux flags are 3'b111, time-out and power-down are 1, and the resume select is 0. The resume select uses 0 for address zero and 1 for PC plus 2.
- R2: A power-on strobe loads main bits [7:1] with 7'b0011110 and leaves bit 0 unchanged. It loads aux with 3'b111 and sets time-out and power-down to 1.
- R3: A brown-out strobe loads main bits [7:2] with 6'b001111 and clears main bit 0 while keeping bit 1. It sets aux bit 1, keeps aux bits 2 and 0, and sets time-out and power-down to 1.
- R4: An external pin reset while awake clears main bit 3 and changes nothing else. The same reset during sleep also clears bit 3, and in addition sets time-out to 1 and clears power-down.
- R5: A watchdog reset clears main bit 4 and clears time-out, leaving power-down unchanged. A watchdog wake clears both time-out and power-down and changes no flag bit.
- R6: A window violation clears main bit 5. A reset instruction clears main bit 2.
- R7: A stack overflow sets main bit 7 and a stack underflow sets main bit 6, but only while the stack-reset enable is 1. While the enable is 0, these strobes change no output.
- R8: A fuse fault clears aux bit 0 and a memory violation clears aux bit 1. A regulator-ready fault clears aux bit 2, loads main bits [7:1] with 7'b0011110 while keeping bit 0, and sets time-out and power-down to 1.
- R9: An interrupt wake sets time-out to 1 and clears power-down, and changes no flag bit.
- R10: Any reset cause makes the resume select 0. A watchdog or interrupt wake with no reset cause in the same cycle makes it 1. Stack strobes while disabled count as no cause.
- R11: Power-on overrides every other strobe in its cycle, and brown-out overrides all strobes except power-on. The remaining strobes merge: a bit that any of them sets becomes 1, otherwise a bit that any of them clears becomes 0.
- R12: With `wr_sel_i`=0 a software write loads main from `wr_data_i`, and with `wr_sel_i`=1 it loads aux from `wr_data_i[2:0]`. The write is dropped when any event strobe is high in that cycle, including a disabled stack strobe.
- R13: Every update appears on the outputs at the clock edge that samples the strobe or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Power-on strobe |
| bor_i | input | 1 | Brown-out strobe |
| pin_rst_awake_i | input | 1 | External pin reset while running |
| pin_rst_sleep_i | input | 1 | External pin reset while sleeping |
| wdt_rst_i | input | 1 | Watchdog time-out reset |
| wdt_wake_i | input | 1 | Watchdog wake from sleep |
| win_viol_i | input | 1 | Watchdog window violation |
| int_wake_i | input | 1 | Interrupt wake from sleep |
| rst_instr_i | input | 1 | Reset instruction executed |
| stk_ovf_i | input | 1 | Stack overflow |
| stk_unf_i | input | 1 | Stack underflow |
| fuse_fault_i | input | 1 | Fuse integrity fault |
| vreg_fault_i | input | 1 | Regulator ready fault |
| mem_viol_i | input | 1 | Memory access violation |
| stk_rst_en_i | input | 1 | Stack reset enable |
| wr_en_i | input | 1 | Software write strobe |
| wr_sel_i | input | 1 | 0 = main register, 1 = aux register |
| wr_data_i | input | 8 | Software write data |
| main_flags_o | output | 8 | Main cause flags |
| aux_flags_o | output | 3 | Aux fault flags |
| to_o | output | 1 | Time-out status bit |
| pd_o | output | 1 | Power-down status bit |
| resume_pc2_o | output | 1 | Resume select, 1 = PC plus 2 |

## Verification
The assertions assume that strobes are single-cycle pulses that are already synchronous to `clk`. They also assume that a software write carrying a register select and data is meaningful only in a cycle the block is free to accept it. The stimulus drives every strobe and write on the falling edge for exactly one rising edge. It combines strobes only in the priority and merge scenarios, so each solo scenario isolates one cause's set, clear and keep pattern. Before each scenario, software writes known values into the registers, so that a kept bit can be told apart from a forced one.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    localparam int MAIN_W = 8;
    localparam int AUX_W  = 3;

    // strobe indices; 0 and 1 carry priority
    localparam int EV_POR       = 0;
    localparam int EV_BOR       = 1;
    localparam int EV_PIN_AWAKE = 2;
    localparam int EV_PIN_SLEEP = 3;
    localparam int EV_WDT_RST   = 4;
    localparam int EV_WDT_WAKE  = 5;
    localparam int EV_WIN       = 6;
    localparam int EV_INT_WAKE  = 7;
    localparam int EV_RST_INSTR = 8;
    localparam int EV_STK_OVF   = 9;
    localparam int EV_STK_UNF   = 10;
    localparam int EV_FUSE      = 11;
    localparam int EV_VREG      = 12;
    localparam int EV_MEM       = 13;
    localparam int NUM_EV       = 14;

    // main register bit positions
    localparam int MB_BOR   = 0;
    localparam int MB_POR   = 1;
    localparam int MB_RI    = 2;
    localparam int MB_PIN   = 3;
    localparam int MB_WDT   = 4;
    localparam int MB_WIN   = 5;
    localparam int MB_UNF   = 6;
    localparam int MB_OVF   = 7;

    // aux register bit positions
    localparam int AB_FUSE  = 0;
    localparam int AB_MEM   = 1;
    localparam int AB_VREG  = 2;

    typedef enum logic {
        RESUME_VECTOR0  = 1'b0,
        RESUME_PC_PLUS2 = 1'b1
    } resume_e;

    typedef struct packed {
        logic [MAIN_W-1:0] main_set;
        logic [MAIN_W-1:0] main_clr;
        logic [AUX_W-1:0]  aux_set;
        logic [AUX_W-1:0]  aux_clr;
        logic              to_set;
        logic              to_clr;
        logic              pd_set;
        logic              pd_clr;
        logic              is_reset;
        logic              is_wake;
    } upd_t;

    // mask of the cold-start main pattern: bits WIN, WDT, PIN, RI set
    function automatic logic [MAIN_W-1:0] cold_set();
        logic [MAIN_W-1:0] m;
        m = '0;
        m[MB_WIN] = 1'b1;
        m[MB_WDT] = 1'b1;
        m[MB_PIN] = 1'b1;
        m[MB_RI]  = 1'b1;
        return m;
    endfunction

    function automatic logic [MAIN_W-1:0] bit_of(int pos);
        logic [MAIN_W-1:0] m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

    function automatic upd_t src_effect(int idx, logic stk_en);
        upd_t u;
        u = '0;
        case (idx)
            EV_POR: begin
                u.main_set = cold_set();
                u.main_clr = bit_of(MB_OVF) | bit_of(MB_UNF) | bit_of(MB_POR);
                u.aux_set  = '1;
                u.to_set   = 1'b1;
                u.pd_set   = 1'b1;
                u.is_reset = 1'b1;
            end
            EV_BOR: begin
                u.main_set = cold_set();
                u.main_clr = bit_of(MB_OVF) | bit_of(MB_UNF) | bit_of(MB_BOR);
                u.aux_set[AB_MEM] = 1'b1;
                u.to_set   = 1'b1;
                u.pd_set   = 1'b1;
                u.is_reset = 1'b1;
            end
            EV_PIN_AWAKE: begin
                u.main_clr = bit_of(MB_PIN);
                u.is_reset = 1'b1;
            end
            EV_PIN_SLEEP: begin
                u.main_clr = bit_of(MB_PIN);
                u.to_set   = 1'b1;
                u.pd_clr   = 1'b1;
                u.is_reset = 1'b1;
            end
            EV_WDT_RST: begin
                u.main_clr = bit_of(MB_WDT);
                u.to_clr   = 1'b1;
                u.is_reset = 1'b1;
            end
            EV_WDT_WAKE: begin
                u.to_clr   = 1'b1;
                u.pd_clr   = 1'b1;
                u.is_wake  = 1'b1;
            end
            EV_WIN: begin
                u.main_clr = bit_of(MB_WIN);
                u.is_reset = 1'b1;
            end
            EV_INT_WAKE: begin
                u.to_set   = 1'b1;
                u.pd_clr   = 1'b1;
                u.is_wake  = 1'b1;
            end
            EV_RST_INSTR: begin
                u.main_clr = bit_of(MB_RI);
                u.is_reset = 1'b1;
            end
            EV_STK_OVF: begin
                if (stk_en) begin
                    u.main_set = bit_of(MB_OVF);
                    u.is_reset = 1'b1;
                end
            end
            EV_STK_UNF: begin
                if (stk_en) begin
                    u.main_set = bit_of(MB_UNF);
                    u.is_reset = 1'b1;
                end
            end
            EV_FUSE: begin
                u.aux_clr[AB_FUSE] = 1'b1;
                u.is_reset = 1'b1;
            end
            EV_VREG: begin
                u.main_set = cold_set();
                u.main_clr = bit_of(MB_OVF) | bit_of(MB_UNF) | bit_of(MB_POR);
                u.aux_clr[AB_VREG] = 1'b1;
                u.to_set   = 1'b1;
                u.pd_set   = 1'b1;
                u.is_reset = 1'b1;
            end
            EV_MEM: begin
                u.aux_clr[AB_MEM] = 1'b1;
                u.is_reset = 1'b1;
            end
            default: u = '0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/rcf_merge.sv
module rcf_merge
    import rcf_pkg::*;
#(
    parameter int N_EV = NUM_EV
) (
    input  logic [N_EV-1:0] ev,
    input  logic            stk_en,
    output upd_t            upd,
    output logic            any_ev
);

    upd_t eff [N_EV];

    for (genvar g = 0; g < N_EV; g++) begin : g_src
        assign eff[g] = src_effect(g, stk_en);
    end

    always_comb begin
        upd = '0;
        if (ev[EV_POR]) begin
            upd = eff[EV_POR];
        end else if (ev[EV_BOR]) begin
            upd = eff[EV_BOR];
        end else begin
            for (int i = EV_BOR + 1; i < N_EV; i++) begin
                if (ev[i]) upd = upd | eff[i];
            end
        end
    end

    assign any_ev = |ev;

endmodule

// File: rtl/rcf_flags.sv
module rcf_flags
    import rcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  upd_t              upd,
    input  logic              any_ev,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [MAIN_W-1:0] wr_data,
    output logic [MAIN_W-1:0] main_q,
    output logic [AUX_W-1:0]  aux_q,
    output logic              to_q,
    output logic              pd_q,
    output resume_e           resume_q
);

    logic [MAIN_W-1:0] main_n;
    logic [AUX_W-1:0]  aux_n;
    logic              to_n, pd_n;
    resume_e           resume_n;

    always_comb begin
        main_n   = main_q;
        aux_n    = aux_q;
        to_n     = to_q;
        pd_n     = pd_q;
        resume_n = resume_q;
        if (any_ev) begin
            // set beats clear when merged sources disagree
            main_n = (main_q & ~upd.main_clr) | upd.main_set;
            aux_n  = (aux_q  & ~upd.aux_clr)  | upd.aux_set;
            to_n   = upd.to_set ? 1'b1 : (upd.to_clr ? 1'b0 : to_q);
            pd_n   = upd.pd_set ? 1'b1 : (upd.pd_clr ? 1'b0 : pd_q);
            if (upd.is_reset)     resume_n = RESUME_VECTOR0;
            else if (upd.is_wake) resume_n = RESUME_PC_PLUS2;
        end else if (wr_en) begin
            if (wr_sel) aux_n  = wr_data[AUX_W-1:0];
            else        main_n = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q   <= cold_set();
            aux_q    <= '1;
            to_q     <= 1'b1;
            pd_q     <= 1'b1;
            resume_q <= RESUME_VECTOR0;
        end else begin
            main_q   <= main_n;
            aux_q    <= aux_n;
            to_q     <= to_n;
            pd_q     <= pd_n;
            resume_q <= resume_n;
        end
    end

    // R12: an idle-cycle write to main lands one edge later
    assert_main_write_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && !any_ev) |=> (main_q == $past(wr_data)));

    // R12: a write coinciding with a strobe must not land if strobe changes nothing
    assert_write_blocked_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && any_ev && upd == '0) |=> ($stable(main_q) && $stable(aux_q)));

endmodule

// File: rtl/rcf_top.sv
module rcf_top
    import rcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              por_i,
    input  logic              bor_i,
    input  logic              pin_rst_awake_i,
    input  logic              pin_rst_sleep_i,
    input  logic              wdt_rst_i,
    input  logic              wdt_wake_i,
    input  logic              win_viol_i,
    input  logic              int_wake_i,
    input  logic              rst_instr_i,
    input  logic              stk_ovf_i,
    input  logic              stk_unf_i,
    input  logic              fuse_fault_i,
    input  logic              vreg_fault_i,
    input  logic              mem_viol_i,
    input  logic              stk_rst_en_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        main_flags_o,
    output logic [2:0]        aux_flags_o,
    output logic              to_o,
    output logic              pd_o,
    output logic              resume_pc2_o
);

    logic [NUM_EV-1:0] ev;
    upd_t              upd;
    logic              any_ev;
    resume_e           resume_q;

    always_comb begin
        ev = '0;
        ev[EV_POR]       = por_i;
        ev[EV_BOR]       = bor_i;
        ev[EV_PIN_AWAKE] = pin_rst_awake_i;
        ev[EV_PIN_SLEEP] = pin_rst_sleep_i;
        ev[EV_WDT_RST]   = wdt_rst_i;
        ev[EV_WDT_WAKE]  = wdt_wake_i;
        ev[EV_WIN]       = win_viol_i;
        ev[EV_INT_WAKE]  = int_wake_i;
        ev[EV_RST_INSTR] = rst_instr_i;
        ev[EV_STK_OVF]   = stk_ovf_i;
        ev[EV_STK_UNF]   = stk_unf_i;
        ev[EV_FUSE]      = fuse_fault_i;
        ev[EV_VREG]      = vreg_fault_i;
        ev[EV_MEM]       = mem_viol_i;
    end

    rcf_merge #(.N_EV(NUM_EV)) u_merge (
        .ev     (ev),
        .stk_en (stk_rst_en_i),
        .upd    (upd),
        .any_ev (any_ev)
    );

    rcf_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .any_ev   (any_ev),
        .wr_en    (wr_en_i),
        .wr_sel   (wr_sel_i),
        .wr_data  (wr_data_i),
        .main_q   (main_flags_o),
        .aux_q    (aux_flags_o),
        .to_q     (to_o),
        .pd_q     (pd_o),
        .resume_q (resume_q)
    );

    assign resume_pc2_o = (resume_q == RESUME_PC_PLUS2);

    logic hard_rst_ev;
    assign hard_rst_ev = por_i | bor_i | pin_rst_awake_i | pin_rst_sleep_i | wdt_rst_i
                       | win_viol_i | rst_instr_i | fuse_fault_i | vreg_fault_i | mem_viol_i
                       | (stk_rst_en_i & (stk_ovf_i | stk_unf_i));

    assert_por_load_R2: assert property (@(posedge clk) disable iff (rst)
        por_i |=> (main_flags_o[7:1] == 7'b0011110 && aux_flags_o == 3'b111 && to_o && pd_o));

    assert_por_keep_bit0_R2: assert property (@(posedge clk) disable iff (rst)
        por_i |=> (main_flags_o[0] == $past(main_flags_o[0])));

    assert_bor_load_R3: assert property (@(posedge clk) disable iff (rst)
        (bor_i && !por_i) |=> (main_flags_o[7:2] == 6'b001111 && !main_flags_o[0]
                               && aux_flags_o[1] && to_o && pd_o));

    assert_resume_zero_R10: assert property (@(posedge clk) disable iff (rst)
        hard_rst_ev |=> !resume_pc2_o);

    assert_resume_wake_R10: assert property (@(posedge clk) disable iff (rst)
        ((wdt_wake_i || int_wake_i) && !hard_rst_ev) |=> resume_pc2_o);

    assert_stack_gate_R7: assert property (@(posedge clk) disable iff (rst)
        ((stk_ovf_i || stk_unf_i) && !stk_rst_en_i && !wr_en_i
         && !(por_i | bor_i | pin_rst_awake_i | pin_rst_sleep_i | wdt_rst_i | wdt_wake_i
              | win_viol_i | int_wake_i | rst_instr_i | fuse_fault_i | vreg_fault_i | mem_viol_i))
        |=> ($stable(main_flags_o) && $stable(aux_flags_o) && $stable(to_o)
             && $stable(pd_o) && $stable(resume_pc2_o)));

endmodule

// File: tb/test_rcf_top.sv
`timescale 1ns/1ps
module test_rcf_top;

    localparam int M_POR = 0,  M_BOR = 1,  M_PINA = 2, M_PINS = 3, M_WRST = 4;
    localparam int M_WWAK = 5, M_WIN = 6,  M_INTW = 7, M_RI = 8,   M_OVF = 9;
    localparam int M_UNF = 10, M_FUSE = 11, M_VREG = 12, M_MEM = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [13:0] ev = '0;
    logic stk_en = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] main_f;
    logic [2:0] aux_f;
    logic to_b, pd_b, res_b;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rcf_top i_rcf_top (
        .clk(clk), .rst(rst),
        .por_i(ev[M_POR]), .bor_i(ev[M_BOR]),
        .pin_rst_awake_i(ev[M_PINA]), .pin_rst_sleep_i(ev[M_PINS]),
        .wdt_rst_i(ev[M_WRST]), .wdt_wake_i(ev[M_WWAK]),
        .win_viol_i(ev[M_WIN]), .int_wake_i(ev[M_INTW]),
        .rst_instr_i(ev[M_RI]), .stk_ovf_i(ev[M_OVF]), .stk_unf_i(ev[M_UNF]),
        .fuse_fault_i(ev[M_FUSE]), .vreg_fault_i(ev[M_VREG]), .mem_viol_i(ev[M_MEM]),
        .stk_rst_en_i(stk_en), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .main_flags_o(main_f), .aux_flags_o(aux_f), .to_o(to_b), .pd_o(pd_b),
        .resume_pc2_o(res_b)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [7:0] m, input logic [2:0] a,
                             input logic t, input logic p, input logic r);
        chk(req, "main", main_f, m);
        chk(req, "aux", {5'b0, aux_f}, {5'b0, a});
        chk(req, "to", {7'b0, to_b}, {7'b0, t});
        chk(req, "pd", {7'b0, pd_b}, {7'b0, p});
        chk(req, "resume", {7'b0, res_b}, {7'b0, r});
    endtask

    // drive strobes and/or a write for one rising edge; outputs settled on return
    task automatic step(input logic [13:0] m, input logic we, input logic sel, input logic [7:0] d);
        @(negedge clk);
        ev = m; wr_en = we; wr_sel = sel; wr_data = d;
        @(negedge clk);
        ev = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    endtask

    task automatic fire(input int idx);
        step(14'(1) << idx, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic sw(input logic sel, input logic [7:0] d);
        step('0, 1'b1, sel, d);
    endtask

    task automatic t_reset;
        chk_state("R1", 8'h3C, 3'b111, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_por;
        sw(1'b0, 8'h01); sw(1'b1, 8'h00);
        chk("R12", "main write", main_f, 8'h01);
        fire(M_POR);
        chk_state("R2", 8'h3D, 3'b111, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_bor;
        sw(1'b0, 8'h02); sw(1'b1, 8'h00);
        fire(M_BOR);
        chk_state("R3", 8'h3E, 3'b010, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_pin_wdt;
        sw(1'b0, 8'hFF);
        fire(M_PINA);
        chk_state("R4", 8'hF7, 3'b010, 1'b1, 1'b1, 1'b0);
        fire(M_WWAK);
        chk_state("R5", 8'hF7, 3'b010, 1'b0, 1'b0, 1'b1);
        sw(1'b0, 8'hFF);
        fire(M_PINS);
        chk_state("R4", 8'hF7, 3'b010, 1'b1, 1'b0, 1'b0);
        sw(1'b0, 8'hFF);
        fire(M_WRST);
        chk_state("R5", 8'hEF, 3'b010, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_win_ri;
        sw(1'b0, 8'hFF);
        fire(M_WIN);
        chk("R6", "window", main_f, 8'hDF);
        fire(M_RI);
        chk("R6", "reset instr", main_f, 8'hDB);
    endtask

    task automatic t_stack;
        fire(M_INTW);
        chk("R10", "wake resume", {7'b0, res_b}, 8'h01);
        sw(1'b0, 8'h00);
        stk_en = 1'b0;
        fire(M_OVF);
        chk_state("R7", 8'h00, 3'b010, 1'b1, 1'b0, 1'b1);
        fire(M_UNF);
        chk_state("R7", 8'h00, 3'b010, 1'b1, 1'b0, 1'b1);
        stk_en = 1'b1;
        fire(M_OVF);
        chk("R7", "ovf", main_f, 8'h80);
        chk("R10", "ovf resume", {7'b0, res_b}, 8'h00);
        fire(M_UNF);
        chk("R7", "unf", main_f, 8'hC0);
    endtask

    task automatic t_aux;
        sw(1'b1, 8'h07);
        fire(M_FUSE);
        chk("R8", "fuse", {5'b0, aux_f}, 8'h06);
        fire(M_MEM);
        chk("R8", "mem", {5'b0, aux_f}, 8'h04);
        fire(M_WWAK);
        sw(1'b0, 8'hC1);
        fire(M_VREG);
        chk_state("R8", 8'h3D, 3'b000, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_int_wake;
        fire(M_WWAK);
        chk_state("R5", 8'h3D, 3'b000, 1'b0, 1'b0, 1'b1);
        fire(M_RI);
        chk("R10", "reset after wake", {7'b0, res_b}, 8'h00);
        fire(M_INTW);
        chk_state("R9", 8'h39, 3'b000, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_priority;
        sw(1'b0, 8'h00); sw(1'b1, 8'h00);
        step((14'(1) << M_POR) | (14'(1) << M_BOR) | (14'(1) << M_WRST), 1'b0, 1'b0, 8'h00);
        chk_state("R11", 8'h3C, 3'b111, 1'b1, 1'b1, 1'b0);
        sw(1'b0, 8'h00); sw(1'b1, 8'h00);
        step((14'(1) << M_BOR) | (14'(1) << M_PINA), 1'b0, 1'b0, 8'h00);
        chk_state("R11", 8'h3C, 3'b010, 1'b1, 1'b1, 1'b0);
        stk_en = 1'b1;
        sw(1'b0, 8'hFF);
        step((14'(1) << M_WRST) | (14'(1) << M_WIN) | (14'(1) << M_OVF), 1'b0, 1'b0, 8'h00);
        chk("R11", "merge main", main_f, 8'hCF);
        chk("R11", "merge to", {7'b0, to_b}, 8'h00);
        sw(1'b0, 8'h00);
        step((14'(1) << M_VREG) | (14'(1) << M_OVF), 1'b0, 1'b0, 8'h00);
        chk("R11", "set beats clear", main_f, 8'hBC);
    endtask

    task automatic t_write;
        sw(1'b0, 8'hFF);
        step(14'(1) << M_PINA, 1'b1, 1'b0, 8'h55);
        chk("R12", "write during strobe", main_f, 8'hF7);
        stk_en = 1'b0;
        step(14'(1) << M_OVF, 1'b1, 1'b0, 8'h55);
        chk("R12", "write during disabled strobe", main_f, 8'hF7);
        sw(1'b1, 8'hFA);
        chk("R12", "aux write", {5'b0, aux_f}, 8'h02);
        // R13: update visible right after the sampling edge, not before
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h3A;
        #1;
        chk("R13", "before edge", main_f, 8'hF7);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R13", "after edge", main_f, 8'h3A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_por();
        t_bor();
        t_pin_wdt();
        t_win_ri();
        t_stack();
        t_aux();
        t_int_wake();
        t_priority();
        t_write();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R13 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule